// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits in front of a 16-bit NOR-style flash model and turns a stream of bus write cycles into operations. Each write carries an address and the low byte of the data word. The decoder follows the two-cycle unlock preamble and the command bytes that come after it. When it recognises a complete command, it emits one operation: word program, sector or chip erase, sector lockdown, identification entry or exit, erase suspend or resume, protection-register program or lock, or entry into a sticky single-pulse program mode.

The memory array and all timing of the operations are handled downstream. That downstream logic takes the one-cycle strobe, the operation code and the captured address and data. It also drives a busy input while an embedded program runs, and the decoder ignores writes during that time. A mode output shows whether the part is in normal read, identification or single-pulse mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While rst_ni is low, and after it is released, op_valid_o is 0 and mode_o is 0 (read). A low rst_ni at any time also drops any partly entered sequence.
- R2: Command addresses are compared on addr_i[10:0] only. The first unlock cycle needs data 0xAA at 0x555. The second needs data 0x55 at 0x2AA. Because bit 11 is ignored, 0xAAA and 0x2AA are both accepted.
- R3: A third cycle of 0x90 at 0x555 gives op code 5 (identification entry) and sets mode_o to 1. A third cycle of 0xF0 at 0x555 gives op code 6 (identification exit) and sets mode_o to 0.
- R4: A third cycle of 0xA0 at 0x555, followed by any fourth write, gives op code 1 (word program) with the address and data of that fourth write.
- R5: A third cycle of 0x80 at 0x555 starts the six-cycle erase family. The fourth cycle is 0xAA at 0x555 and the fifth is 0x55 at 0x2AA. The sixth cycle then decides the operation: 0x10 at 0x555 gives op code 3 (chip erase), 0x30 at any address gives op code 2 (sector erase), and 0x60 at any address gives op code 4 (sector lockdown). The sixth cycle's address is captured.
- R6: From idle, a single write decodes on its own: 0xB0 at any address gives op code 7 (erase suspend), 0x30 gives op code 8 (erase resume) with the address captured, and 0xF0 gives op code 6 (identification exit).
- R7: A third cycle of 0xC0 at 0x555, followed by a fourth write, gives op code 10 (protection lock) when addr_i[10:0] is 0x080. Any other fourth address gives op code 9 (protection program). The fourth write's data is captured in both cases.
- R8: A sixth erase-family cycle of 0xA0 at 0x555 gives op code 11 and sets mode_o to 2 (single-pulse). In that mode every accepted write gives op code 1 with its own address and data, including 0x30 and 0xB0 writes. Only reset leaves mode 2.
- R9: A write while busy_i is high has no effect. It produces no strobe, and a sequence in progress continues as if that write had not happened.
- R10: A write that does not fit the sequence in progress returns the decoder to idle. That write is not re-examined as the start of a new sequence.
- R11: op_valid_o is high for exactly the cycle after the edge that accepts the completing write. op_addr_o and op_data_o hold the captured values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Bus write cycle present this clock |
| addr_i | input | 20 | Word address of the write |
| data_i | input | 8 | Low data byte of the write |
| busy_i | input | 1 | Embedded program in progress; writes ignored |
| op_valid_o | output | 1 | One-cycle operation strobe |
| op_code_o | output | 4 | Decoded operation code |
| op_addr_o | output | 20 | Address captured with the operation |
| op_data_o | output | 8 | Data captured with the operation |
| mode_o | output | 2 | 0 read, 1 identification, 2 single-pulse program |

## Verification
Each result appears one clock after the edge that samples the completing write. That holds for the strobe, the code, the captured address and data, and the mode. Writes that do not complete a command produce no strobe in that same cycle. The bench raises a write at a falling edge, lowers it at the next falling edge, and samples all outputs at that second falling edge, which is exactly one rising edge after acceptance. Sweeps over every third-cycle byte and every sixth-cycle byte are followed by a probe write, so the state left behind by each byte becomes visible at the ports.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_WPROG    = 4'd1,
    OP_SERASE   = 4'd2,
    OP_CERASE   = 4'd3,
    OP_SLOCK    = 4'd4,
    OP_ID_ENTRY = 4'd5,
    OP_ID_EXIT  = 4'd6,
    OP_SUSPEND  = 4'd7,
    OP_RESUME   = 4'd8,
    OP_PREG_PRG = 4'd9,
    OP_PREG_LCK = 4'd10,
    OP_SPP_ENTR = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_ID   = 2'd1,
    MODE_SPP  = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PROG, ST_PREG, ST_E3, ST_E4, ST_E5
  } seq_e;

  typedef struct packed {
    logic at_first;   // 0x555
    logic at_second;  // 0x2AA (bit 11 ignored)
    logic at_plock;   // 0x080
  } cyc_cls_t;
endpackage

// File: rtl/flash_cyc_class.sv
module flash_cyc_class
  import flash_cmd_pkg::*;
#(
  parameter int MATCH_W = 11
) (
  input  logic [MATCH_W-1:0] addr_i,
  output cyc_cls_t           cls_o
);
  localparam logic [MATCH_W-1:0] FIRST_A  = MATCH_W'(12'h555);
  localparam logic [MATCH_W-1:0] SECOND_A = MATCH_W'(12'h2AA);
  localparam logic [MATCH_W-1:0] PLOCK_A  = MATCH_W'(12'h080);

  always_comb begin
    cls_o.at_first  = (addr_i == FIRST_A);
    cls_o.at_second = (addr_i == SECOND_A);
    cls_o.at_plock  = (addr_i == PLOCK_A);
  end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  logic     busy_i,
  input  logic [7:0] data_i,
  input  cyc_cls_t cls_i,
  input  logic     spp_i,
  output logic     hit_o,
  output op_e      code_o
);
  seq_e st_q, st_d;
  logic accept;

  assign accept = wr_i && !busy_i;

  always_comb begin
    st_d   = st_q;
    hit_o  = 1'b0;
    code_o = OP_NONE;
    if (accept) begin
      if (spp_i) begin
        hit_o  = 1'b1;
        code_o = OP_WPROG;
        st_d   = ST_IDLE;
      end else begin
        st_d = ST_IDLE;
        unique case (st_q)
          ST_IDLE: begin
            if (cls_i.at_first && data_i == 8'hAA) st_d = ST_U1;
            else if (data_i == 8'hF0) begin hit_o = 1'b1; code_o = OP_ID_EXIT; end
            else if (data_i == 8'hB0) begin hit_o = 1'b1; code_o = OP_SUSPEND; end
            else if (data_i == 8'h30) begin hit_o = 1'b1; code_o = OP_RESUME;  end
          end
          ST_U1: if (cls_i.at_second && data_i == 8'h55) st_d = ST_U2;
          ST_U2: if (cls_i.at_first) begin
            case (data_i)
              8'hA0: st_d = ST_PROG;
              8'h80: st_d = ST_E3;
              8'hC0: st_d = ST_PREG;
              8'h90: begin hit_o = 1'b1; code_o = OP_ID_ENTRY; end
              8'hF0: begin hit_o = 1'b1; code_o = OP_ID_EXIT;  end
              default: ;
            endcase
          end
          ST_PROG: begin hit_o = 1'b1; code_o = OP_WPROG; end
          ST_PREG: begin
            hit_o  = 1'b1;
            code_o = cls_i.at_plock ? OP_PREG_LCK : OP_PREG_PRG;
          end
          ST_E3: if (cls_i.at_first && data_i == 8'hAA) st_d = ST_E4;
          ST_E4: if (cls_i.at_second && data_i == 8'h55) st_d = ST_E5;
          ST_E5: begin
            if (data_i == 8'h30) begin hit_o = 1'b1; code_o = OP_SERASE; end
            else if (data_i == 8'h60) begin hit_o = 1'b1; code_o = OP_SLOCK; end
            else if (cls_i.at_first && data_i == 8'h10) begin
              hit_o = 1'b1; code_o = OP_CERASE;
            end else if (cls_i.at_first && data_i == 8'hA0) begin
              hit_o = 1'b1; code_o = OP_SPP_ENTR;
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
endmodule

// File: rtl/flash_op_reg.sv
module flash_op_reg
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  op_e               code_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output op_e               code_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output mode_e             mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= OP_NONE;
      addr_o  <= '0;
      data_o  <= '0;
      mode_o  <= MODE_READ;
    end else begin
      valid_o <= hit_i;
      if (hit_i) begin
        code_o <= code_i;
        addr_o <= addr_i;
        data_o <= data_i;
        case (code_i)
          OP_ID_ENTRY: mode_o <= MODE_ID;
          OP_ID_EXIT:  mode_o <= MODE_READ;
          OP_SPP_ENTR: mode_o <= MODE_SPP;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 8,
  parameter int MATCH_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              busy_i,
  output logic              op_valid_o,
  output logic [3:0]        op_code_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [1:0]        mode_o
);
  cyc_cls_t cls;
  logic     hit;
  op_e      code, code_q;
  mode_e    mode_q;

  flash_cyc_class #(.MATCH_W(MATCH_W)) u_cls (
    .addr_i (addr_i[MATCH_W-1:0]),
    .cls_o  (cls)
  );

  flash_seq_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .busy_i (busy_i),
    .data_i (data_i[7:0]),
    .cls_i  (cls),
    .spp_i  (mode_q == MODE_SPP),
    .hit_o  (hit),
    .code_o (code)
  );

  flash_op_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .code_i  (code),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .valid_o (op_valid_o),
    .code_o  (code_q),
    .addr_o  (op_addr_o),
    .data_o  (op_data_o),
    .mode_o  (mode_q)
  );

  assign op_code_o = code_q;
  assign mode_o    = mode_q;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 8,
  parameter int MATCH_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              busy_i,
  input logic              op_valid_o,
  input logic [3:0]        op_code_o,
  input logic [ADDR_W-1:0] op_addr_o,
  input logic [DATA_W-1:0] op_data_o,
  input logic [1:0]        mode_o
);
  assert_strobe_src_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> $past(wr_i && !busy_i));
  assert_capture_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> (op_addr_o == $past(addr_i) && op_data_o == $past(data_i)));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_o |-> ($stable(op_addr_o) && $stable(op_data_o)));
  assert_busy_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !op_valid_o);
  assert_spp_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd2 |=> mode_o == 2'd2);
  assert_spp_prog_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && wr_i && !busy_i) |=> (op_valid_o && op_code_o == 4'd1));
  assert_id_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_code_o == 4'd5) |-> mode_o == 2'd1);
  assert_code_known_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> (op_code_o != 4'd0 && op_code_o <= 4'd11));
  assert_mode_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MATCH_W(MATCH_W)
) u_chk (.*);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [19:0] addr = '0;
  logic [7:0]  data = '0;
  logic        busy = 1'b0;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [19:0] op_addr;
  logic [7:0]  op_data;
  logic [1:0]  mode;

  int checks = 0;
  int errors = 0;
  logic        g_v;
  logic [3:0]  g_c;
  logic [19:0] g_a;
  logic [7:0]  g_d;

  always #4 clk = ~clk;

  flash_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .data_i(data),
    .busy_i(busy), .op_valid_o(op_valid), .op_code_o(op_code),
    .op_addr_o(op_addr), .op_data_o(op_data), .mode_o(mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr = 1'b0; busy = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wcyc(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; data = d;
    @(negedge clk);
    wr = 1'b0;
    g_v = op_valid; g_c = op_code; g_a = op_addr; g_d = op_data;
  endtask

  // expect a strobe (or none) after the last wcyc
  task automatic exp_op(input string tag, input bit v, input logic [3:0] c,
                        input logic [19:0] a, input logic [7:0] d);
    if (!v) chk(g_v == 1'b0, tag, g_v, 0);
    else chk(g_v && g_c == c && g_a == a && g_d == d, tag,
             {g_v, g_c, g_a, g_d}, {1'b1, c, a, d});
  endtask

  task automatic unlock(input logic [19:0] second);
    wcyc(20'h00555, 8'hAA);
    wcyc(second, 8'h55);
  endtask

  task automatic erase_pre();
    unlock(20'h00AAA);
    wcyc(20'h00555, 8'h80);
    wcyc(20'h00555, 8'hAA);
    wcyc(20'h002AA, 8'h55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    chk(op_valid == 1'b0 && mode == 2'd0, "R1 in reset", {op_valid, mode}, 0);
    do_reset();
    @(negedge clk);
    chk(op_valid == 1'b0 && mode == 2'd0, "R1 after reset", {op_valid, mode}, 0);

    // R2 / R3 unlock with AAA, 2AA, and A11-set first address
    unlock(20'h00AAA); wcyc(20'h00555, 8'h90);
    exp_op("R2 R3 id entry via AAA", 1, 4'd5, 20'h00555, 8'h90);
    chk(mode == 2'd1, "R3 mode id", mode, 1);
    unlock(20'h002AA); wcyc(20'h00555, 8'hF0);
    exp_op("R2 R3 id exit via 2AA", 1, 4'd6, 20'h00555, 8'hF0);
    chk(mode == 2'd0, "R3 mode read", mode, 0);
    wcyc(20'h30D55, 8'hAA); wcyc(20'h00AAA, 8'h55); wcyc(20'h00D55, 8'h90);
    exp_op("R2 A11 ignored", 1, 4'd5, 20'h00D55, 8'h90);
    wcyc(20'h00555, 8'hAA); wcyc(20'h003AA, 8'h55); wcyc(20'h00555, 8'h90);
    exp_op("R2 wrong second address", 0, 0, 0, 0);

    // R4 word program
    unlock(20'h00AAA); wcyc(20'h00555, 8'hA0);
    exp_op("R4 no strobe on cmd cycle", 0, 0, 0, 0);
    wcyc(20'h9ABCD, 8'h5A);
    exp_op("R4 word program", 1, 4'd1, 20'h9ABCD, 8'h5A);
    @(negedge clk);
    chk(op_valid == 1'b0 && op_addr == 20'h9ABCD, "R11 single cycle and hold",
        {op_valid, op_addr}, 20'h9ABCD);

    // R3/R4/R7/R10 sweep over third-cycle byte, probe with 00@123
    for (int d = 0; d < 256; d++) begin
      bit iv; logic [3:0] ic; bit pv; logic [3:0] pc;
      unlock(20'h00AAA); wcyc(20'h00555, 8'(d));
      iv = (d == 8'h90) || (d == 8'hF0);
      ic = (d == 8'h90) ? 4'd5 : 4'd6;
      exp_op("R3 third-cycle sweep", iv, ic, 20'h00555, 8'(d));
      wcyc(20'h00123, 8'h00);
      pv = (d == 8'hA0) || (d == 8'hC0);
      pc = (d == 8'hA0) ? 4'd1 : 4'd9;
      exp_op("R4 R7 R10 probe sweep", pv, pc, 20'h00123, 8'h00);
    end

    // R5 sweep of sixth byte at a sector address
    for (int d = 0; d < 256; d++) begin
      bit v; logic [3:0] c;
      erase_pre(); wcyc(20'h45000, 8'(d));
      v = (d == 8'h30) || (d == 8'h60);
      c = (d == 8'h30) ? 4'd2 : 4'd4;
      exp_op("R5 sixth sweep sector addr", v, c, 20'h45000, 8'(d));
    end
    // R5 sweep of sixth byte at 555 (A0 covered by R8)
    for (int d = 0; d < 256; d++) begin
      bit v; logic [3:0] c;
      if (d == 8'hA0) continue;
      erase_pre(); wcyc(20'h00555, 8'(d));
      v = (d == 8'h10) || (d == 8'h30) || (d == 8'h60);
      c = (d == 8'h10) ? 4'd3 : (d == 8'h30) ? 4'd2 : 4'd4;
      exp_op("R5 sixth sweep 555", v, c, 20'h00555, 8'(d));
    end

    // R6 single-cycle commands
    wcyc(20'h12345, 8'hB0);
    exp_op("R6 suspend", 1, 4'd7, 20'h12345, 8'hB0);
    wcyc(20'hC0000, 8'h30);
    exp_op("R6 resume plane addr", 1, 4'd8, 20'hC0000, 8'h30);
    wcyc(20'h00077, 8'hF0);
    exp_op("R6 single exit", 1, 4'd6, 20'h00077, 8'hF0);
    wcyc(20'h00077, 8'h55);
    exp_op("R6 other byte no op", 0, 0, 0, 0);

    // R7 protection lock / program
    unlock(20'h00AAA); wcyc(20'h00555, 8'hC0); wcyc(20'h00080, 8'h00);
    exp_op("R7 preg lock", 1, 4'd10, 20'h00080, 8'h00);
    unlock(20'h00AAA); wcyc(20'h00555, 8'hC0); wcyc(20'h00085, 8'h3C);
    exp_op("R7 preg program", 1, 4'd9, 20'h00085, 8'h3C);

    // R10 mismatch not re-examined
    wcyc(20'h00555, 8'hAA); wcyc(20'h00555, 8'hAA);
    wcyc(20'h00AAA, 8'h55); wcyc(20'h00555, 8'h90);
    exp_op("R10 abort not re-examined", 0, 0, 0, 0);
    chk(mode == 2'd0, "R10 mode unchanged", mode, 0);

    // R9 busy ignored
    busy = 1'b1; wcyc(20'h00000, 8'hB0); busy = 1'b0;
    exp_op("R9 busy single cmd", 0, 0, 0, 0);
    wcyc(20'h00555, 8'hAA);
    busy = 1'b1; wcyc(20'h00000, 8'h12); busy = 1'b0;
    wcyc(20'h00AAA, 8'h55); wcyc(20'h00555, 8'h90);
    exp_op("R9 busy write skipped in sequence", 1, 4'd5, 20'h00555, 8'h90);
    wcyc(20'h0, 8'hF0);

    // R1 reset mid-sequence
    unlock(20'h00AAA); wcyc(20'h00555, 8'hA0);
    do_reset();
    wcyc(20'h00123, 8'h00);
    exp_op("R1 reset aborts sequence", 0, 0, 0, 0);

    // R8 single-pulse mode
    erase_pre(); wcyc(20'h00555, 8'hA0);
    exp_op("R8 spp entry", 1, 4'd11, 20'h00555, 8'hA0);
    chk(mode == 2'd2, "R8 mode spp", mode, 2);
    wcyc(20'h45000, 8'h30);
    exp_op("R8 erase byte becomes program", 1, 4'd1, 20'h45000, 8'h30);
    wcyc(20'h00000, 8'hB0);
    exp_op("R8 suspend byte becomes program", 1, 4'd1, 20'h00000, 8'hB0);
    wcyc(20'h00555, 8'hAA);
    exp_op("R8 unlock byte becomes program", 1, 4'd1, 20'h00555, 8'hAA);
    unlock(20'h00AAA); wcyc(20'h00555, 8'hF0);
    exp_op("R8 exit cmd becomes program", 1, 4'd1, 20'h00555, 8'hF0);
    chk(mode == 2'd2, "R8 mode sticky", mode, 2);
    do_reset();
    @(negedge clk);
    chk(mode == 2'd0, "R8 R1 reset leaves spp", mode, 0);
    wcyc(20'h45000, 8'h30);
    exp_op("R8 normal decode after reset", 1, 4'd8, 20'h45000, 8'h30);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule